// File: doc/BRIEF.md
# Age-Ordered Interrupt Status Aggregator

This block merges two level-sensitive external interrupt lines and eight DMA-channel event pulses into a single host interrupt output. Software talks to it through a small register port with three word-wide registers: an enable register built from write-1 enable/disable bit pairs, a status register that can be read with no side effects, and a volatile alias of that status register whose read consumes the condition it reports.

Each status read describes exactly one condition, which is the highest-priority one pending. An enabled external line that is asserted beats any DMA event. DMA events are served in the order they arrived, through a queue of channel indices. External conditions are only reported here and must be cleared at their source. An "additional" flag in every status word tells an interrupt handler whether to read again, so it can drain all pending work with a simple loop.

Register offsets on `reg_addr_i`: 0 is the enable register, 1 is the side-effect-free status register, 2 is the volatile status register, and 3 reads as zero. Read data is combinational from the current address and state. A volatile read takes effect at the clock edge where `reg_rd_i` is high.

Top module: `irq_status_agg`

## Requirements
- R1: After reset, all source enables and the global enable are off. The DMA queue is empty, `host_irq_o` is 0, and both status registers read 0.
- R2: In the enable register, pair k (k=0 global, k=1 external line 0, k=2 external line 1) has its enable bit at bit 2k and its disable bit at bit 2k+1. Writing 1 to the enable bit turns the source on and writing 1 to the disable bit turns it off. A 0 in either bit leaves the source unchanged. If both bits are 1, the disable wins.
- R3: Reading the enable register returns, for pair k, bit 2k = 1 when the source is enabled and bit 2k+1 = 1 when it is disabled. All other bits read 0.
- R4: Status word layout: bit 31 Int (something pending), bit 30 Additional, bit 29 External, bit 28 DMA, bits [7:4] DMA channel index (valid only when DMA is set), and bits [9:8] the enabled, asserted external lines (line 0 at bit 8, valid only when External is set). When any enabled external line is asserted, the word reports External and not DMA.
- R5: A volatile read never clears an external condition. The external condition keeps being reported while its line stays enabled and asserted. DMA conditions become visible once the line deasserts or is disabled.
- R6: Among pending DMA events, the channel whose event arrived earliest is reported first.
- R7: A channel that is already queued is not queued again. Several channels raising events in the same cycle are queued in ascending channel order.
- R8: Additional is 1 when at least one more condition is pending beyond the reported one. For an external report, that means any DMA event is pending. For a DMA report, it means more than one DMA event is queued.
- R9: A volatile read while a DMA condition is reported removes that channel from the queue. Int therefore drops after the last internal condition has been read.
- R10: A read at the status offset (1) changes no state.
- R11: `host_irq_o` is 1 exactly when the global enable is on and either an enabled external line is asserted or the DMA queue is non-empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ext_irq_i | input | 2 | External level interrupt lines |
| dma_evt_i | input | 8 | DMA channel event pulses, one per channel |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (only affects the volatile offset) |
| reg_addr_i | input | 2 | Register offset |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the current offset |
| host_irq_o | output | 1 | Host interrupt request |

## Verification
The bench goes after the following corner cases:
- A channel re-raising its event while still queued. A design that queued it twice would report the same channel twice.
- A popped channel raising a new event in the same cycle. This should land at the tail, not be lost.
- Simultaneous multi-channel arrivals. Reversed ordering would show up as a wrong channel index on the next read.
- Volatile reads made while an external line dominates. A design that popped there would silently lose DMA events.
- Enable writes with both bits of a pair set, and writes of zero, which would expose a set-wins or toggle implementation.
- Every status word, checked for its Additional bit at the one-to-zero pending boundary.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    RA_MASK  = 2'd0,
    RA_STAT  = 2'd1,
    RA_VSTAT = 2'd2,
    RA_NONE  = 2'd3
  } reg_addr_e;

  localparam int BIT_INT  = 31;
  localparam int BIT_MORE = 30;
  localparam int BIT_EXT  = 29;
  localparam int BIT_DMA  = 28;
  localparam int CH_LSB   = 4;
  localparam int LINE_LSB = 8;

  // next state of one enable: disable bit has priority, zeros hold
  function automatic logic next_enable(logic cur, logic set_b, logic clr_b);
    if (clr_b) return 1'b0;
    if (set_b) return 1'b1;
    return cur;
  endfunction

  // combine flag bits with a pre-positioned detail field
  function automatic logic [DATA_W-1:0] status_word(logic intr, logic more,
                                                    logic ext, logic dma,
                                                    logic [DATA_W-1:0] detail);
    logic [DATA_W-1:0] w;
    w = detail;
    w[BIT_INT]  = intr;
    w[BIT_MORE] = more;
    w[BIT_EXT]  = ext;
    w[BIT_DMA]  = dma;
    return w;
  endfunction

endpackage

// File: rtl/irq_mask_regs.sv
module irq_mask_regs #(
  parameter int NUM_EXT = 2,
  localparam int NPAIR  = NUM_EXT + 1,
  localparam int MASK_W = 2 * NPAIR
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [MASK_W-1:0] wbits,
  output logic              glob_en,
  output logic [NUM_EXT-1:0] line_en,
  output logic [MASK_W-1:0] rd_word
);
  import irq_agg_pkg::*;

  logic [NPAIR-1:0] en_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else if (wr_en) begin
      for (int k = 0; k < NPAIR; k++)
        en_q[k] <= next_enable(en_q[k], wbits[2*k], wbits[2*k+1]);
    end
  end

  generate
    for (genvar k = 0; k < NPAIR; k++) begin : g_rb
      assign rd_word[2*k]   = en_q[k];
      assign rd_word[2*k+1] = ~en_q[k];
    end
  endgenerate

  assign glob_en = en_q[0];
  assign line_en = en_q[NPAIR-1:1];

  // disable bit always wins when both bits are written
  p_clear_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wbits[1]) |=> !glob_en);
  p_zero_write_holds_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wbits == '0) |=> $stable(en_q));

endmodule

// File: rtl/irq_age_queue.sv
module irq_age_queue #(
  parameter int NUM_CH = 8,
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] evt,
  input  logic              pop,
  output logic [CH_W-1:0]   head,
  output logic [CNT_W-1:0]  count,
  output logic              empty
);

  logic [CH_W-1:0]   q_q   [NUM_CH];
  logic [CH_W-1:0]   q_d   [NUM_CH];
  logic [NUM_CH-1:0] inq_q, inq_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              pop_eff;

  assign pop_eff = pop && (cnt_q != '0);

  always_comb begin
    int n;
    q_d   = q_q;
    inq_d = inq_q;
    n     = int'(cnt_q);
    if (pop_eff) begin
      inq_d[q_q[0]] = 1'b0;
      for (int i = 0; i < NUM_CH - 1; i++) q_d[i] = q_q[i+1];
      n = n - 1;
    end
    for (int ch = 0; ch < NUM_CH; ch++) begin
      if (evt[ch] && !inq_d[ch] && n < NUM_CH) begin
        q_d[n]    = CH_W'(ch);
        inq_d[ch] = 1'b1;
        n         = n + 1;
      end
    end
    cnt_d = CNT_W'(n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) q_q[i] <= '0;
      inq_q <= '0;
      cnt_q <= '0;
    end else begin
      q_q   <= q_d;
      inq_q <= inq_d;
      cnt_q <= cnt_d;
    end
  end

  assign head  = q_q[0];
  assign count = cnt_q;
  assign empty = (cnt_q == '0);

  // one entry per queued channel, never beyond capacity (R7)
  p_unique_entries_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(inq_q) == int'(cnt_q));
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cnt_q) <= NUM_CH);
  p_head_is_queued_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |-> inq_q[head]);

endmodule

// File: rtl/irq_status_agg.sv
module irq_status_agg #(
  parameter int NUM_EXT = 2,
  parameter int NUM_DMA = 8,
  localparam int DW     = irq_agg_pkg::DATA_W,
  localparam int MASK_W = 2 * (NUM_EXT + 1),
  localparam int CH_W   = (NUM_DMA > 1) ? $clog2(NUM_DMA) : 1,
  localparam int CNT_W  = $clog2(NUM_DMA + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic [NUM_DMA-1:0] dma_evt_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [1:0]         reg_addr_i,
  input  logic [DW-1:0]      reg_wdata_i,
  output logic [DW-1:0]      reg_rdata_o,
  output logic               host_irq_o
);
  import irq_agg_pkg::*;

  logic               glob_en;
  logic [NUM_EXT-1:0] line_en;
  logic [MASK_W-1:0]  mask_rd;
  logic               mask_wr;
  logic [CH_W-1:0]    head_ch;
  logic [CNT_W-1:0]   dma_cnt;
  logic               dma_empty;

  // named events used by assertions
  logic [NUM_EXT-1:0] ext_act;
  logic               ext_hit;
  logic               dma_pend;
  logic               vol_rd;
  logic               stat_rd;
  logic               pop_dma;
  logic               more;
  logic [DW-1:0]      detail;
  logic [DW-1:0]      status;

  assign mask_wr = reg_wr_i && (reg_addr_e'(reg_addr_i) == RA_MASK);

  irq_mask_regs #(.NUM_EXT(NUM_EXT)) u_mask (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mask_wr),
    .wbits   (reg_wdata_i[MASK_W-1:0]),
    .glob_en (glob_en),
    .line_en (line_en),
    .rd_word (mask_rd)
  );

  assign ext_act  = ext_irq_i & line_en;
  assign ext_hit  = |ext_act;
  assign dma_pend = !dma_empty;
  assign vol_rd   = reg_rd_i && (reg_addr_e'(reg_addr_i) == RA_VSTAT);
  assign stat_rd  = reg_rd_i && (reg_addr_e'(reg_addr_i) == RA_STAT);
  assign pop_dma  = vol_rd && !ext_hit && dma_pend;

  irq_age_queue #(.NUM_CH(NUM_DMA)) u_queue (
    .clk   (clk),
    .rst_n (rst_n),
    .evt   (dma_evt_i),
    .pop   (pop_dma),
    .head  (head_ch),
    .count (dma_cnt),
    .empty (dma_empty)
  );

  always_comb begin
    detail = '0;
    more   = 1'b0;
    if (ext_hit) begin
      detail[LINE_LSB +: NUM_EXT] = ext_act;
      more = dma_pend;
    end else if (dma_pend) begin
      detail[CH_LSB +: CH_W] = head_ch;
      more = (dma_cnt > CNT_W'(1));
    end
    status = status_word(ext_hit || dma_pend, more, ext_hit,
                         !ext_hit && dma_pend, detail);
  end

  always_comb begin
    unique case (reg_addr_e'(reg_addr_i))
      RA_MASK:           reg_rdata_o = DW'(mask_rd);
      RA_STAT, RA_VSTAT: reg_rdata_o = status;
      default:           reg_rdata_o = '0;
    endcase
  end

  assign host_irq_o = glob_en && (ext_hit || dma_pend);

  p_ext_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ext_hit |-> (status[BIT_EXT] && !status[BIT_DMA]));
  p_vol_keeps_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vol_rd && ext_hit) |=> dma_cnt >= $past(dma_cnt));
  p_pop_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_dma && dma_evt_i == '0) |=> int'(dma_cnt) == int'($past(dma_cnt)) - 1);
  p_stat_read_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !reg_wr_i && dma_evt_i == '0) |=> ($stable(dma_cnt) && $stable(head_ch)));
  p_irq_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq_o |-> (glob_en && status[BIT_INT]));

endmodule

// File: tb/irq_status_agg_bench.sv
`timescale 1ns/1ps
module irq_status_agg_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  ext_irq = '0;
  logic [7:0]  dma_evt = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        host_irq;

  always #2 clk = ~clk;   // 250 MHz

  irq_status_agg u_irq_status_agg (
    .clk(clk), .rst_n(rst_n), .ext_irq_i(ext_irq), .dma_evt_i(dma_evt),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .host_irq_o(host_irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  // reference model
  bit m_en [3];
  int m_q [8];
  int m_n;

  function automatic bit m_ext_hit();
    return (ext_irq[0] && m_en[1]) || (ext_irq[1] && m_en[2]);
  endfunction

  function automatic logic [31:0] exp_read(logic [1:0] a);
    logic [31:0] w = 0;
    if (a == 2'd0) begin
      for (int k = 0; k < 3; k++) begin
        w[2*k] = m_en[k]; w[2*k+1] = !m_en[k];
      end
    end else if (a == 2'd1 || a == 2'd2) begin
      if (m_ext_hit()) begin
        w[31] = 1; w[29] = 1; w[30] = (m_n > 0);
        w[8] = ext_irq[0] && m_en[1];
        w[9] = ext_irq[1] && m_en[2];
      end else if (m_n > 0) begin
        w[31] = 1; w[28] = 1; w[30] = (m_n > 1);
        w[7:4] = 4'(m_q[0]);
      end
    end
    return w;
  endfunction

  function automatic bit exp_irq();
    return m_en[0] && (m_ext_hit() || m_n > 0);
  endfunction

  function automatic bit m_has(int ch);
    for (int i = 0; i < m_n; i++) if (m_q[i] == ch) return 1;
    return 0;
  endfunction

  task automatic model_step();
    if (rd && addr == 2'd2 && !m_ext_hit() && m_n > 0) begin
      for (int i = 0; i < 7; i++) m_q[i] = m_q[i+1];
      m_n--;
    end
    if (wr && addr == 2'd0)
      for (int k = 0; k < 3; k++)
        if (wdata[2*k+1]) m_en[k] = 0; else if (wdata[2*k]) m_en[k] = 1;
    for (int ch = 0; ch < 8; ch++)
      if (dma_evt[ch] && !m_has(ch)) begin m_q[m_n] = ch; m_n++; end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one clock of stimulus with checks before the edge
  task automatic step(string tag, bit w, bit r, logic [1:0] a, logic [31:0] d,
                      logic [7:0] e, logic [1:0] x);
    @(negedge clk);
    wr = w; rd = r; addr = a; wdata = d; dma_evt = e; ext_irq = x;
    #1;
    chk({tag, " rdata"}, rdata, exp_read(a));
    chk("R11 host_irq", {31'd0, host_irq}, {31'd0, exp_irq()});
    model_step();
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 3; k++) m_en[k] = 0;
    m_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state, R3 readback
    step("R1 R3 mask after reset", 0, 0, 2'd0, 0, 0, 0);
    step("R1 status after reset", 0, 1, 2'd1, 0, 0, 0);
    step("R1 vstatus after reset", 0, 1, 2'd2, 0, 0, 0);
    // R2 set, zero, both-bits
    step("R2 write", 1, 0, 2'd0, 32'h15, 0, 0);
    step("R3 readback all on", 0, 0, 2'd0, 0, 0, 0);
    step("R2 zero write", 1, 0, 2'd0, 32'h0, 0, 0);
    step("R2 zero holds", 0, 0, 2'd0, 0, 0, 0);
    step("R2 both bits", 1, 0, 2'd0, 32'h0C, 0, 0);
    step("R2 clear wins", 0, 0, 2'd0, 0, 0, 0);
    step("R2 reenable", 1, 0, 2'd0, 32'h04, 0, 0);
    // R6 R7 ordering: 5, 2, 5 again, then 3 and 1 together
    step("R7 evt5", 0, 0, 2'd1, 0, 8'h20, 0);
    step("R7 evt2", 0, 0, 2'd1, 0, 8'h04, 0);
    step("R7 evt5 dup", 0, 0, 2'd1, 0, 8'h20, 0);
    step("R7 evt3+1", 0, 0, 2'd1, 0, 8'h0A, 0);
    step("R10 stat read", 0, 1, 2'd1, 0, 0, 0);
    step("R10 stat read again", 0, 1, 2'd1, 0, 0, 0);
    // R4 R5 external dominates, volatile read keeps queue
    step("R4 ext0", 0, 1, 2'd2, 0, 0, 2'b01);
    step("R5 ext persists", 0, 1, 2'd2, 0, 0, 2'b11);
    step("R5 mask ext0", 1, 0, 2'd0, 32'h08, 0, 2'b11);
    step("R4 ext1 only", 0, 1, 2'd2, 0, 0, 2'b11);
    step("R5 ext1 drop", 0, 1, 2'd1, 0, 0, 2'b01);
    // R6 R8 R9 drain, with popped channel re-raising
    step("R6 R9 pop 5", 0, 1, 2'd2, 0, 8'h20, 0);
    step("R6 R9 pop 2", 0, 1, 2'd2, 0, 0, 0);
    step("R8 pop 1", 0, 1, 2'd2, 0, 0, 0);
    step("R8 pop 3", 0, 1, 2'd2, 0, 0, 0);
    step("R9 pop 5 last", 0, 1, 2'd2, 0, 0, 0);
    step("R9 empty", 0, 1, 2'd2, 0, 0, 0);
    step("R11 global off", 1, 0, 2'd0, 32'h02, 8'h01, 0);
    step("R11 pending no irq", 0, 0, 2'd1, 0, 0, 0);
    // random phase
    begin
      int seed = 17;
      logic [1:0] x = 0;
      void'($urandom(seed));
      for (int i = 0; i < 4000; i++) begin
        int op = $urandom_range(0, 9);
        logic [7:0] e = ($urandom_range(0, 3) == 0) ? 8'($urandom) & 8'($urandom) : 8'h0;
        if ($urandom_range(0, 15) == 0) x = 2'($urandom);
        if (op < 2)      step("R2 R3 rand mask", 1, 0, 2'd0, {26'd0, 6'($urandom)}, e, x);
        else if (op < 4) step("R4 R10 rand stat", 0, 1, 2'd1, 0, e, x);
        else if (op < 8) step("R6 R8 R9 rand vstat", 0, 1, 2'd2, 0, e, x);
        else             step("R7 rand idle", 0, 0, 2'($urandom), 0, e, x);
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule